// File: doc/BRIEF.md
# Quarter-Period Oversampling Time-to-Digital Converter Channel

This block timestamps the rising edges of one asynchronous hit line. The reference clock is supplied as four copies offset by 0, 90, 180 and 270 degrees. Each copy samples the hit line once per reference period, so one period is cut into four quarter slots. A free-running coarse counter on the reference clock supplies the high part of each timestamp. The quarter slot where the hit first appears supplies a 2-bit fine code. The phase clocks are ports because they come from a clock generator outside the block, and one set of them can serve many channels.

Every rising edge seen in a sampling window is reported, so the channel is multi-hit. A window spans one reference period and holds one sample from each phase. Each report is one word pushed into a small FIFO and presented on a valid/ready stream. While `out_valid` is high and `out_ready` is low, the word at the head stays on `out_data` unchanged. A word leaves on every rising edge of `clk_ph0` where both signals are high. If a new hit finds the FIFO full, that hit is dropped and the sticky `overflow` pin rises.

Top module: `quad_phase_tdc`

## Requirements
- R1: A clock edge with `rst` high clears the coarse counter, the stored previous sample, the FIFO and `overflow`. After that edge `out_valid` and `overflow` read 0.
- R2: Phase k (k = 0..3) samples the hit line k quarter periods after the reference edge that opens a window. When the first sampled 1 that follows a 0 is at phase k, the fine code is 3 - k. A later arrival therefore gives a smaller code.
- R3: The coarse field is the number of `clk_ph0` rising edges with `rst` low, counted up to and including the edge that opens the window. Only the lowest COARSE_W bits are kept.
- R4: A rise after the phase-270 sample and before the next reference edge belongs to the window that edge opens, with fine code 3.
- R5: A window produces at most one word. A second rise inside the same window, closer than one window to the first, is merged into the first and adds no word.
- R6: Rises in separate windows each produce their own word, in arrival order. This holds even when two rises are only half a period apart across a window boundary.
- R7: The first window after reset (coarse value 1) is used only as history and is never reported. A hit line that is held high through reset therefore produces no word.
- R8: `out_data` is {coarse[COARSE_W-1:0], fine[1:0]}, with the fine code in bits 1:0. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: The FIFO holds FIFO_DEPTH words (4 by default). A hit that arrives while the FIFO is full and no word leaves in that cycle is dropped and sets `overflow`. `overflow` stays set until reset.
- R10: The coarse field wraps to 0 after 2^COARSE_W - 1 without any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph0 | input | 1 | Reference clock, phase 0; clocks the counter, encoder and stream |
| clk_ph90 | input | 1 | Reference clock delayed by a quarter period |
| clk_ph180 | input | 1 | Reference clock delayed by half a period |
| clk_ph270 | input | 1 | Reference clock delayed by three quarter periods |
| rst | input | 1 | Synchronous reset, active high, in the clk_ph0 domain |
| hit_in | input | 1 | Asynchronous hit line; rising edges are timestamped |
| out_valid | output | 1 | A timestamp word is available |
| out_ready | input | 1 | The consumer accepts the word this cycle |
| out_data | output | COARSE_W+2 | Timestamp {coarse, fine} |
| overflow | output | 1 | Sticky flag: a hit was dropped because the FIFO was full |

## Verification
The bench places a single rise in each of the four quarter slots. This separates the four fine codes from each other and shows that a rise just before a reference edge is credited to the following window. A glitch that rises, falls and rises again within one window shows that the two rises are merged into one word. Two rises half a period apart across a window boundary show that both are kept as separate words. Holding the consumer off while five hits arrive tests the stall, the drop and the sticky flag. A hit held high through reset, and a hit placed after the counter has wrapped, cover the start-up history and the wrap.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  localparam int NUM_PHASES = 4;
  localparam int FINE_W     = 2;

  typedef logic [NUM_PHASES-1:0] window_t;

  // Returns {found, fine}; fine counts quarter slots left after the first rise.
  function automatic logic [FINE_W:0] first_rise(input window_t win, input logic prev);
    logic [FINE_W:0] res;
    logic            last;
    res  = '0;
    last = prev;
    for (int i = 0; i < NUM_PHASES; i++) begin
      if (!res[FINE_W] && win[i] && !last)
        res = {1'b1, FINE_W'(NUM_PHASES - 1 - i)};
      last = win[i];
    end
    return res;
  endfunction
endpackage

// File: rtl/tdc_phase_sampler.sv
`timescale 1ns/1ps
module tdc_phase_sampler import tdc_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_PHASES-1:0] phase_clk,
  input  logic                  hit_in,
  output window_t               window_q
);
  window_t tap;

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
    logic [SYNC_STAGES-1:0] chain;
    // each phase keeps its sample in its own domain for SYNC_STAGES periods
    always_ff @(posedge phase_clk[k]) begin
      chain <= {chain[SYNC_STAGES-2:0], hit_in};
    end
    assign tap[k] = chain[SYNC_STAGES-1];
  end

  // one capture on phase 0 gathers four samples of the same period
  always_ff @(posedge phase_clk[0]) begin
    window_q <= tap;
  end
endmodule

// File: rtl/tdc_timebase.sv
`timescale 1ns/1ps
module tdc_timebase #(
  parameter int COARSE_W   = 8,
  parameter int ARM_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  output logic [COARSE_W-1:0] coarse_q,
  output logic                armed
);
  localparam int ARM_W = $clog2(ARM_CYCLES + 1);

  logic [ARM_W-1:0] arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q <= '0;
      arm_q    <= '0;
    end else begin
      coarse_q <= coarse_q + 1'b1;
      if (arm_q != ARM_W'(ARM_CYCLES))
        arm_q <= arm_q + 1'b1;
    end
  end

  assign armed = (arm_q == ARM_W'(ARM_CYCLES));
endmodule

// File: rtl/tdc_hit_encoder.sv
`timescale 1ns/1ps
module tdc_hit_encoder import tdc_pkg::*; #(
  parameter int COARSE_W = 8,
  parameter int LAG      = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  window_t                    window,
  input  logic                       armed,
  input  logic [COARSE_W-1:0]        coarse,
  output logic                       push_q,
  output logic [COARSE_W+FINE_W-1:0] word_q
);
  logic              prev_q;
  logic [FINE_W:0]   rise;
  logic [COARSE_W-1:0] tag;

  assign rise = first_rise(window, prev_q);
  // the window in hand was opened LAG edges before the current count
  assign tag  = coarse - COARSE_W'(LAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      push_q <= 1'b0;
      word_q <= '0;
    end else begin
      prev_q <= window[NUM_PHASES-1];
      push_q <= armed && rise[FINE_W];
      word_q <= {tag, rise[FINE_W-1:0]};
    end
  end
endmodule

// File: rtl/tdc_word_fifo.sv
`timescale 1ns/1ps
module tdc_word_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr;
  logic             full, pop, accept;

  assign out_valid = (wr_ptr != rd_ptr);
  assign full      = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign pop       = out_valid && out_ready;
  assign accept    = push && (!full || pop);
  assign out_data  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (pop)    rd_ptr <= rd_ptr + 1'b1;
      if (push && full && !pop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/quad_phase_tdc.sv
`timescale 1ns/1ps
module quad_phase_tdc import tdc_pkg::*; #(
  parameter int COARSE_W    = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_ph0,
  input  logic                       clk_ph90,
  input  logic                       clk_ph180,
  input  logic                       clk_ph270,
  input  logic                       rst,
  input  logic                       hit_in,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [COARSE_W+FINE_W-1:0] out_data,
  output logic                       overflow
);
  localparam int WORD_W     = COARSE_W + FINE_W;
  localparam int ARM_CYCLES = SYNC_STAGES + 2;

  window_t             window;
  logic [COARSE_W-1:0] coarse;
  logic                armed;
  logic                push;
  logic [WORD_W-1:0]   word;

  tdc_phase_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .phase_clk ({clk_ph270, clk_ph180, clk_ph90, clk_ph0}),
    .hit_in    (hit_in),
    .window_q  (window)
  );

  tdc_timebase #(.COARSE_W(COARSE_W), .ARM_CYCLES(ARM_CYCLES)) u_timebase (
    .clk      (clk_ph0),
    .rst      (rst),
    .coarse_q (coarse),
    .armed    (armed)
  );

  tdc_hit_encoder #(.COARSE_W(COARSE_W), .LAG(SYNC_STAGES)) u_encoder (
    .clk    (clk_ph0),
    .rst    (rst),
    .window (window),
    .armed  (armed),
    .coarse (coarse),
    .push_q (push),
    .word_q (word)
  );

  tdc_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk_ph0),
    .rst       (rst),
    .push      (push),
    .push_data (word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .overflow  (overflow)
  );
endmodule

// File: rtl/quad_phase_tdc_checker.sv
`timescale 1ns/1ps
module quad_phase_tdc_checker #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              overflow
);
  logic rst_seen_q;
  initial rst_seen_q = 1'b0;
  always @(posedge clk) rst_seen_q <= rst;

  always @(posedge clk) begin
    if (rst_seen_q) begin
      AST_RESET_EMPTY: assert (!out_valid && !overflow) else $error("reset left state"); // R1
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)) else $error("stall broken"); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow) else $error("overflow cleared"); // R9

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(out_valid && !out_ready)) else $error("overflow without stall"); // R9
endmodule

bind quad_phase_tdc quad_phase_tdc_checker #(.WORD_W(COARSE_W + 2)) u_checker (
  .clk       (clk_ph0),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .overflow  (overflow)
);

// File: tb/quad_phase_tdc_test.sv
`timescale 1ns/1ps
module quad_phase_tdc_test;
  localparam int CLK_PERIOD = 8;
  localparam int CW = 8;
  localparam int W  = CW + 2;
  // {slot[1:0], glitch, fine[1:0], next_window}
  localparam logic [5:0] VEC_TABLE [5] = '{
    {2'd1, 1'b0, 2'd2, 1'b0},   // R2 slot 90
    {2'd2, 1'b0, 2'd1, 1'b0},   // R2 slot 180
    {2'd3, 1'b0, 2'd0, 1'b0},   // R2 slot 270
    {2'd0, 1'b0, 2'd3, 1'b1},   // R4 boundary
    {2'd1, 1'b1, 2'd2, 1'b0}    // R5 glitch
  };

  logic clk0, clk90, clk180, clk270;
  logic rst, hit, out_ready, out_valid, overflow;
  logic [W-1:0] out_data;
  int ecount;
  int total, failed;
  logic [W-1:0] got_q [$];

  quad_phase_tdc #(.COARSE_W(CW)) uut (
    .clk_ph0(clk0), .clk_ph90(clk90), .clk_ph180(clk180), .clk_ph270(clk270),
    .rst(rst), .hit_in(hit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .overflow(overflow)
  );

  initial begin clk0 = 0; forever #(CLK_PERIOD/2) clk0 = ~clk0; end
  initial begin clk90 = 0; #(CLK_PERIOD/4); forever #(CLK_PERIOD/2) clk90 = ~clk90; end
  initial begin clk180 = 0; #(CLK_PERIOD/2); forever #(CLK_PERIOD/2) clk180 = ~clk180; end
  initial begin clk270 = 0; #(3*CLK_PERIOD/4); forever #(CLK_PERIOD/2) clk270 = ~clk270; end

  always @(posedge clk0) ecount <= rst ? 0 : ecount + 1;
  always @(negedge clk0) if (out_valid && out_ready) got_q.push_back(out_data);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk0);
    #1;
  endtask

  // returns the window count at the opening edge; slot offsets in ns after it
  task automatic pulse(input int slot, input bit glitch, output int n);
    @(posedge clk0); #1;
    n = ecount;
    if (glitch) begin
      hit = 1; #2 hit = 0; #2 hit = 1; #10 hit = 0;
    end else begin
      #(2*((slot+3)%4));
      hit = 1; #10 hit = 0;
    end
  endtask

  function automatic logic [W-1:0] stamp(input int n, input int f);
    return {CW'(n), 2'(f)};
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n, m;
    int ns [5];
    total = 0; failed = 0; ecount = 0;
    rst = 1; hit = 1; out_ready = 1;
    cycles(4);
    check(out_valid == 0, "R1 valid in reset", out_valid, 0);
    check(overflow == 0, "R1 overflow in reset", overflow, 0);
    rst = 0;
    cycles(10);
    check(got_q.size() == 0, "R7 held hit", got_q.size(), 0);
    check(out_valid == 0, "R7 valid", out_valid, 0);
    hit = 0;
    cycles(4);
    got_q.delete();

    for (int v = 0; v < 5; v++) begin
      logic [5:0] e;
      e = VEC_TABLE[v];
      pulse(int'(e[5:4]), e[3], n);
      cycles(6);
      check(got_q.size() == 1, "R5 one word per window", got_q.size(), 1);
      if (got_q.size() > 0)
        check(got_q[0] == stamp(n + int'(e[0]), int'(e[2:1])), "R2 R3 R4 word",
              got_q[0], stamp(n + int'(e[0]), int'(e[2:1])));
      got_q.delete();
    end

    // R6: rise at slot 270, then again at slot 90 of the next window
    @(posedge clk0); #1;
    n = ecount;
    #4 hit = 1; #2 hit = 0; #2 hit = 1; #10 hit = 0;
    cycles(6);
    check(got_q.size() == 2, "R6 count", got_q.size(), 2);
    if (got_q.size() == 2) begin
      check(got_q[0] == stamp(n, 0), "R6 first", got_q[0], stamp(n, 0));
      check(got_q[1] == stamp(n + 1, 2), "R6 second", got_q[1], stamp(n + 1, 2));
    end
    got_q.delete();

    // R9 and R8: stall, fill, drop
    @(posedge clk0); #1; out_ready = 0;
    for (int k = 0; k < 5; k++) begin pulse(1, 1'b0, m); ns[k] = m; end
    cycles(6);
    check(overflow == 1, "R9 overflow set", overflow, 1);
    check(out_valid == 1, "R8 valid held", out_valid, 1);
    check(out_data == stamp(ns[0], 2), "R8 head word", out_data, stamp(ns[0], 2));
    cycles(3);
    check(out_data == stamp(ns[0], 2), "R8 stable in stall", out_data, stamp(ns[0], 2));
    out_ready = 1;
    cycles(8);
    check(got_q.size() == 4, "R9 kept words", got_q.size(), 4);
    for (int k = 0; k < 4; k++)
      if (k < got_q.size())
        check(got_q[k] == stamp(ns[k], 2), "R9 order", got_q[k], stamp(ns[k], 2));
    check(overflow == 1, "R9 sticky", overflow, 1);
    got_q.delete();
    rst = 1;
    cycles(2);
    check(overflow == 0, "R1 overflow cleared", overflow, 0);
    check(out_valid == 0, "R1 fifo cleared", out_valid, 0);
    rst = 0;

    // R10: coarse wrap
    while (ecount < 300) cycles(1);
    pulse(2, 1'b0, n);
    cycles(6);
    check(got_q.size() == 1, "R10 count", got_q.size(), 1);
    if (got_q.size() > 0)
      check(got_q[0] == stamp(n % 256, 1), "R10 wrapped", got_q[0], stamp(n % 256, 1));
    report();
  end
endmodule